// File: doc/BRIEF.md
# Two-Wire Slave Command Interface

This block is the slave side of an open-drain two-wire serial bus, used to reach a small set of 6-bit control registers. It runs on the system clock. It synchronizes the clock and data lines and detects START and STOP conditions. It then checks the first byte against a fixed device identifier and three strap pins. The second byte is an instruction: a 4-bit opcode plus a 2-bit register select.

What happens after the instruction depends on the opcode. A transfer command ends there. A write command takes one more data byte from the master. A read command shifts a register value out to the master. The stepping command opens a mode in which every bus clock moves the value by one step. Commands reach a register controller through a one-cycle strobe that carries the opcode, the register select and the data. Read data comes back from the controller on a parallel input.

The block drives SDA only by pulling it low, through an output-enable. The address is not acknowledged while the controller reports a nonvolatile write in progress, so the master can poll until the write has finished.

Top module: `twi_cmd_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state abandons the current transaction, releases SDA and begins reception of a new address byte.
- R2: The address byte is bits 7..4 = 0101, bit 3 = dev_sel_i[2], bit 2 = dev_sel_i[1], bit 1 = 0, bit 0 = dev_sel_i[0]. Bytes are sent MSB first. Only a full match is acknowledged (SDA pulled low during the ninth clock). On a mismatch the block stays silent, ignores the bus until the next START and issues no command.
- R3: While nv_busy_i is high when the address byte completes, the address is not acknowledged, even if it matches.
- R4: The instruction byte holds the opcode in bits 7..4, the register select in bits 3..2, and bits 1..0 unused. The accepted opcodes are 1001, 1010, 1011, 1100, 1101, 1110 and 0010. Any other opcode is not acknowledged, no command is issued, and the block idles until the next START.
- R5: The transfer opcodes 1101 and 1110 are acknowledged. At the SCL fall that ends that acknowledge, the block gives a one-cycle cmd_valid_o pulse with cmd_op_o equal to the opcode and cmd_reg_o equal to the register select.
- R6: The write opcodes 1010 and 1100 take a third byte, which is acknowledged. The block then pulses cmd_valid_o with cmd_data_o equal to that byte's low 6 bits; its upper two bits are ignored.
- R7: The read opcodes 1001 and 1011 present cmd_op_o and cmd_reg_o to the controller. After the instruction acknowledge, the block shifts out two 0 bits and then rd_data_i, MSB first. It releases SDA after the eighth bit and issues no cmd_valid_o pulse.
- R8: After opcode 0010 is acknowledged, every SCL rise gives one step_valid_o pulse, with step_up_o equal to SDA (1 = up). This includes the rise that precedes the closing STOP. cmd_valid_o and step_valid_o are never high together.
- R9: The SDA output-enable changes only while SCL is low, or on a START or STOP.
- R10: After reset, sda_oe_o, cmd_valid_o and step_valid_o are low.
- R11: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_sel_i | input | 3 | Strap bits matched against address bits 3, 2 and 0 |
| nv_busy_i | input | 1 | Nonvolatile write in progress; address refused |
| rd_data_i | input | 6 | Register value returned for the selected read |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the last accepted instruction |
| cmd_reg_o | output | 2 | Register select of the last accepted instruction |
| cmd_data_o | output | 6 | Data from the last write byte |
| step_valid_o | output | 1 | One-cycle step strobe |
| step_up_o | output | 1 | Step direction, 1 = up |

## Verification
The bench builds the block with its defaults: a 6-bit value width and two synchronizer stages. With these, a bus half-period of eight system clocks leaves several cycles between a detected SCL edge and the next master action. That margin lets the bench sample acknowledge and read bits mid-high and still see an SDA output-enable change that arrives late. Because the value width leaves two padding bits in every data byte, the bench can check that the upper bits of a write are ignored and that the upper bits of a read come back as zeros.

// File: rtl/twi_cmd_pkg.sv
package twi_cmd_pkg;

    localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
    localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
    localparam logic [3:0] OPC_RD_STORE = 4'b1011;
    localparam logic [3:0] OPC_WR_STORE = 4'b1100;
    localparam logic [3:0] OPC_XF_LOAD  = 4'b1101;
    localparam logic [3:0] OPC_XF_SAVE  = 4'b1110;
    localparam logic [3:0] OPC_STEP     = 4'b0010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA,
        ST_ACK_WAIT, ST_ACK, ST_TX, ST_STEP, ST_HOLD
    } twi_state_e;

    typedef enum logic [1:0] {
        BY_ADDR, BY_INSTR, BY_DATA
    } byte_kind_e;

    typedef enum logic [2:0] {
        CL_BAD, CL_READ, CL_WRITE, CL_XFER, CL_STEP
    } op_class_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign sda_lvl_o  = lvl[0];
    assign scl_rise_o = lvl[1] & ~prev_q[1];
    assign scl_fall_o = ~lvl[1] & prev_q[1];
    assign start_o    = lvl[1] & prev_q[1] & prev_q[0] & ~lvl[0];
    assign stop_o     = lvl[1] & prev_q[1] & ~prev_q[0] & lvl[0];

endmodule

// File: rtl/twi_op_decode.sv
module twi_op_decode
    import twi_cmd_pkg::*;
(
    input  logic [3:0] opcode_i,
    output op_class_e  cls_o
);
    always_comb begin
        case (opcode_i)
            OPC_RD_WIPER, OPC_RD_STORE: cls_o = CL_READ;
            OPC_WR_WIPER, OPC_WR_STORE: cls_o = CL_WRITE;
            OPC_XF_LOAD,  OPC_XF_SAVE:  cls_o = CL_XFER;
            OPC_STEP:                   cls_o = CL_STEP;
            default:                    cls_o = CL_BAD;
        endcase
    end
endmodule

// File: rtl/twi_cmd_core.sv
module twi_cmd_core
    import twi_cmd_pkg::*;
#(
    parameter int         VAL_W  = 6,
    parameter logic [3:0] DEV_ID = 4'b0101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_lvl_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [2:0]       dev_sel_i,
    input  logic             nv_busy_i,
    input  logic [VAL_W-1:0] rd_data_i,
    output logic             sda_oe_o,
    output logic             cmd_valid_o,
    output logic [3:0]       cmd_op_o,
    output logic [1:0]       cmd_reg_o,
    output logic [VAL_W-1:0] cmd_data_o,
    output logic             step_valid_o,
    output logic             step_up_o
);
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - VAL_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        twi_state_e        st;
        byte_kind_e        kind;
        op_class_e         cls;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-2:0] sh;
        logic [3:0]        op;
        logic [1:0]        rsel;
        logic [VAL_W-1:0]  data;
        logic [BYTE_W-1:0] tx;
        logic              oe;
        logic              cmd_v;
        logic              step_v;
        logic              step_up;
    } core_state_t;

    localparam core_state_t RST = '{
        st: ST_IDLE, kind: BY_ADDR, cls: CL_BAD, bitcnt: '0, sh: '0,
        op: '0, rsel: '0, data: '0, tx: '0, oe: 1'b0, cmd_v: 1'b0,
        step_v: 1'b0, step_up: 1'b0
    };

    core_state_t q, d;
    logic [BYTE_W-1:0] byte_full;
    logic [BYTE_W-1:0] tx_load;
    op_class_e         dec_cls;
    logic              addr_hit;

    assign byte_full = {q.sh, sda_lvl_i};
    assign tx_load   = {{PAD_W{1'b0}}, rd_data_i};
    assign addr_hit  = (byte_full[7:4] == DEV_ID) && (byte_full[3] == dev_sel_i[2])
                    && (byte_full[2] == dev_sel_i[1]) && !byte_full[1]
                    && (byte_full[0] == dev_sel_i[0]);

    twi_op_decode u_dec (
        .opcode_i (byte_full[7:4]),
        .cls_o    (dec_cls)
    );

    always_comb begin
        d        = q;
        d.cmd_v  = 1'b0;
        d.step_v = 1'b0;
        if (start_i) begin
            d.st     = ST_ADDR;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise_i) begin
                        d.sh     = byte_full[BYTE_W-2:0];
                        d.bitcnt = q.bitcnt + 1'b1;
                        if (q.bitcnt == CNT_W'(BYTE_W - 1)) begin
                            d.bitcnt = '0;
                            d.st     = ST_IDLE;
                            if (q.st == ST_ADDR) begin
                                if (addr_hit && !nv_busy_i) begin
                                    d.st   = ST_ACK_WAIT;
                                    d.kind = BY_ADDR;
                                end
                            end else if (q.st == ST_INSTR) begin
                                if (dec_cls != CL_BAD) begin
                                    d.st   = ST_ACK_WAIT;
                                    d.kind = BY_INSTR;
                                    d.cls  = dec_cls;
                                    d.op   = byte_full[7:4];
                                    d.rsel = byte_full[3:2];
                                end
                            end else begin
                                d.st   = ST_ACK_WAIT;
                                d.kind = BY_DATA;
                                d.data = byte_full[VAL_W-1:0];
                            end
                        end
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall_i) begin
                        d.oe = 1'b1;
                        d.st = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        case (q.kind)
                            BY_ADDR:  d.st = ST_INSTR;
                            BY_DATA: begin
                                d.cmd_v = 1'b1;
                                d.st    = ST_HOLD;
                            end
                            default: begin
                                case (q.cls)
                                    CL_READ: begin
                                        d.st = ST_TX;
                                        d.tx = tx_load;
                                        d.oe = ~tx_load[BYTE_W-1];
                                    end
                                    CL_WRITE: d.st = ST_WDATA;
                                    CL_STEP:  d.st = ST_STEP;
                                    CL_XFER: begin
                                        d.cmd_v = 1'b1;
                                        d.st    = ST_HOLD;
                                    end
                                    default:  d.st = ST_IDLE;
                                endcase
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.bitcnt >= CNT_W'(BYTE_W)) begin
                            d.oe = 1'b0;
                            d.st = ST_HOLD;
                        end else begin
                            d.oe = ~q.tx[3'(CNT_W'(BYTE_W - 1) - q.bitcnt)];
                        end
                    end
                end
                ST_STEP: begin
                    if (scl_rise_i) begin
                        d.step_v  = 1'b1;
                        d.step_up = sda_lvl_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign sda_oe_o     = q.oe;
    assign cmd_valid_o  = q.cmd_v;
    assign cmd_op_o     = q.op;
    assign cmd_reg_o    = q.rsel;
    assign cmd_data_o   = q.data;
    assign step_valid_o = q.step_v;
    assign step_up_o    = q.step_up;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall_i || start_i || stop_i)); // R9
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK_WAIT && $past(q.st) == ST_ADDR) |-> !$past(nv_busy_i)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe); // R11
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmd_v |=> !q.cmd_v); // R5
    AST_STEP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        q.step_v |-> ($past(q.st) == ST_STEP && $past(scl_rise_i))); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.cmd_v, q.step_v})); // R8
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_ADDR && !q.oe)); // R1

endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave #(
    parameter int VAL_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [2:0]       dev_sel_i,
    input  logic             nv_busy_i,
    input  logic [VAL_W-1:0] rd_data_i,
    output logic             cmd_valid_o,
    output logic [3:0]       cmd_op_o,
    output logic [1:0]       cmd_reg_o,
    output logic [VAL_W-1:0] cmd_data_o,
    output logic             step_valid_o,
    output logic             step_up_o
);
    logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    twi_cmd_core #(.VAL_W(VAL_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sda_lvl_i    (sda_lvl),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (start_ev),
        .stop_i       (stop_ev),
        .dev_sel_i    (dev_sel_i),
        .nv_busy_i    (nv_busy_i),
        .rd_data_i    (rd_data_i),
        .sda_oe_o     (sda_oe_o),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_op_o     (cmd_op_o),
        .cmd_reg_o    (cmd_reg_o),
        .cmd_data_o   (cmd_data_o),
        .step_valid_o (step_valid_o),
        .step_up_o    (step_up_o)
    );
endmodule

// File: tb/sim_twi_cmd_slave.sv
module sim_twi_cmd_slave;
    localparam int H = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] dev_sel = 3'b101;
    logic       nv_busy = 1'b0;
    logic [5:0] rd_data = 6'h00;
    logic       sda_oe, cmd_valid, step_valid, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg;
    logic [5:0] cmd_data;
    wire        bus_sda = m_sda & ~sda_oe;

    twi_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_oe_o(sda_oe), .dev_sel_i(dev_sel), .nv_busy_i(nv_busy),
        .rd_data_i(rd_data), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
        .cmd_reg_o(cmd_reg), .cmd_data_o(cmd_data),
        .step_valid_o(step_valid), .step_up_o(step_up)
    );

    int n_tests = 0, n_fail = 0;
    int cmd_cnt = 0, step_cnt = 0, step_ups = 0, oe_viol = 0, both_hi = 0;
    logic [3:0] c_op;
    logic [1:0] c_reg;
    logic [5:0] c_data;
    logic       oe_prev = 1'b0;
    bit         done = 1'b0;

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_cnt++; c_op = cmd_op; c_reg = cmd_reg; c_data = cmd_data;
        end
        if (step_valid) begin
            step_cnt++; step_ups += int'(step_up);
        end
        if (cmd_valid && step_valid) both_hi++;
        if (sda_oe != oe_prev && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] addr_byte(input logic [2:0] s);
        return {4'b0101, s[2], s[1], 1'b0, s[0]};
    endfunction
    function automatic logic [7:0] instr_byte(input logic [3:0] op, input logic [1:0] r);
        return {op, r, 2'b00};
    endfunction
    function automatic logic [5:0] exp_wdata(input logic [7:0] b);
        return b[5:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(H);
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(2*H);
    endtask
    task automatic send_bit(input logic b);
        m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    endtask
    task automatic send_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
        ack = !bus_sda; wt(H/2); m_scl = 1'b0;
    endtask
    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2);
            v[i] = bus_sda; wt(H/2); m_scl = 1'b0;
        end
        send_bit(1'b1);
    endtask

    // Full command with a third byte (write) or without (transfer)
    task automatic do_cmd(input logic [3:0] op, input logic [1:0] r, input bit has_data,
                          input logic [7:0] dat, output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_byte(instr_byte(op, r), a1);
        a2 = 1'b0;
        if (has_data) send_byte(dat, a2);
        bus_stop();
    endtask

    task automatic do_read(input logic [3:0] op, input logic [1:0] r, output bit a0,
                           output bit a1, output logic [7:0] v);
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_byte(instr_byte(op, r), a1);
        recv_byte(v);
        bus_stop();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit a0, a1, a2;
        logic [7:0] v;
        int base, sb, su;
        void'($urandom(32'd4711));
        wt(5);
        check(sda_oe == 1'b0 && cmd_valid == 1'b0 && step_valid == 1'b0,
              "R10 reset outputs", int'(sda_oe), 0);
        rst_n = 1'b1;
        wt(10);

        // R2 mismatch: no ack, nothing issued
        base = cmd_cnt;
        bus_start();
        send_byte(addr_byte(dev_sel ^ 3'b010), a0);
        check(!a0, "R2 mismatched address ack", int'(a0), 0);
        send_byte(instr_byte(4'b1101, 2'd1), a1);
        check(!a1, "R2 ignored after mismatch", int'(a1), 0);
        bus_stop();
        check(cmd_cnt == base, "R2 no command after mismatch", cmd_cnt - base, 0);

        // R3 busy refuses address
        nv_busy = 1'b1;
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        bus_stop();
        nv_busy = 1'b0;
        check(!a0, "R3 address ack while busy", int'(a0), 0);

        // R4 unknown opcode
        base = cmd_cnt;
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_byte(instr_byte(4'b0111, 2'd0), a1);
        bus_stop();
        check(a0, "R2 matched address ack", int'(a0), 1);
        check(!a1, "R4 unknown opcode ack", int'(a1), 0);
        check(cmd_cnt == base, "R4 unknown opcode command", cmd_cnt - base, 0);

        // R5 transfer
        base = cmd_cnt;
        do_cmd(4'b1101, 2'd2, 1'b0, 8'h00, a0, a1, a2);
        check(a1, "R5 transfer instr ack", int'(a1), 1);
        check(cmd_cnt == base + 1 && c_op == 4'b1101 && c_reg == 2'd2,
              "R5 transfer strobe", int'({c_op, c_reg}), int'({4'b1101, 2'd2}));
        do_cmd(4'b1110, 2'd3, 1'b0, 8'h00, a0, a1, a2);
        check(cmd_cnt == base + 2 && c_op == 4'b1110 && c_reg == 2'd3,
              "R5 save strobe", int'({c_op, c_reg}), int'({4'b1110, 2'd3}));

        // R6 write with upper bits set
        do_cmd(4'b1010, 2'd0, 1'b1, 8'hFF, a0, a1, a2);
        check(a2, "R6 data ack", int'(a2), 1);
        check(c_op == 4'b1010 && c_data == 6'h3F, "R6 upper bits ignored", int'(c_data), 63);
        do_cmd(4'b1100, 2'd3, 1'b1, 8'h95, a0, a1, a2);
        check(c_op == 4'b1100 && c_reg == 2'd3 && c_data == exp_wdata(8'h95),
              "R6 store write data", int'(c_data), int'(exp_wdata(8'h95)));

        // R7 read
        base = cmd_cnt;
        rd_data = 6'h2A;
        do_read(4'b1011, 2'd1, a0, a1, v);
        check(a1 && v == 8'h2A, "R7 read byte", int'(v), 42);
        check(cmd_cnt == base, "R7 read issues no strobe", cmd_cnt - base, 0);
        rd_data = 6'h3F;
        do_read(4'b1001, 2'd0, a0, a1, v);
        check(v == 8'h3F, "R7 read padding zeros", int'(v), 63);

        // R8 stepping: pattern 1,1,0,1,1 plus the down step before STOP
        sb = step_cnt; su = step_ups;
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_byte(instr_byte(4'b0010, 2'd0), a1);
        send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        bus_stop();
        check(a1, "R8 step instr ack", int'(a1), 1);
        check(step_cnt - sb == 6, "R8 step count", step_cnt - sb, 6);
        check(step_ups - su == 4, "R8 up steps", step_ups - su, 4);

        // R1 START mid-instruction aborts, then a fresh command works
        base = cmd_cnt;
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_bit(1); send_bit(1); send_bit(0);
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        send_byte(instr_byte(4'b1101, 2'd0), a1);
        bus_stop();
        check(a0 && a1 && cmd_cnt == base + 1 && c_reg == 2'd0,
              "R1 restart after START", cmd_cnt - base, 1);

        // R11 STOP after address: idle, released
        base = cmd_cnt;
        bus_start();
        send_byte(addr_byte(dev_sel), a0);
        bus_stop();
        check(sda_oe == 1'b0 && cmd_cnt == base, "R11 stop to idle", int'(sda_oe), 0);

        // Random mix
        for (int it = 0; it < 30; it++) begin
            int kind;
            logic [1:0] r;
            logic [7:0] dat;
            kind = int'($urandom % 5);
            r    = 2'($urandom);
            dat  = 8'($urandom);
            dev_sel = 3'($urandom);
            wt(2);
            base = cmd_cnt;
            case (kind)
                0, 1: begin
                    do_cmd(kind == 0 ? 4'b1010 : 4'b1100, r, 1'b1, dat, a0, a1, a2);
                    check(a0 && a1 && a2 && cmd_cnt == base + 1 &&
                          c_data == exp_wdata(dat), "R6 random write",
                          int'(c_data), int'(exp_wdata(dat)));
                end
                2, 3: begin
                    rd_data = dat[5:0];
                    do_read(kind == 2 ? 4'b1001 : 4'b1011, r, a0, a1, v);
                    check(a0 && a1 && v == {2'b00, dat[5:0]} && cmd_op == (kind == 2 ? 4'b1001 : 4'b1011),
                          "R7 random read", int'(v), int'({2'b00, dat[5:0]}));
                end
                default: begin
                    do_cmd(dat[0] ? 4'b1101 : 4'b1110, r, 1'b0, 8'h00, a0, a1, a2);
                    check(a0 && a1 && cmd_cnt == base + 1 && c_reg == r,
                          "R5 random transfer", int'(c_reg), int'(r));
                end
            endcase
        end

        check(oe_viol == 0, "R9 drive change while SCL high", oe_viol, 0);
        check(both_hi == 0, "R8 strobes exclusive", both_hi, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule